// File: doc/BRIEF.md
# Latched One-of-Sixteen Decoder

This block turns a 4-bit binary code into a one-hot selection of sixteen lines. A holding stage sits in front of the decoder. While the strobe input is high, that stage passes the code straight through, so the lines follow the data inputs in the same cycle. When the strobe drops, the stage keeps the last code it captured while the strobe was high, and later changes on the data inputs have no effect. An inhibit input blanks the outputs. Every line goes to its inactive level, and the held code is kept.

An elaboration parameter sets the output polarity. In the active-high form the chosen line is 1 and the others are 0. In the active-low form every line is the inverse of the active-high form. A typical use is to steer a single serial bit, carried on the inhibit input, onto one of sixteen destinations picked by the held code.

The holding stage is built as a clock-enabled register with a combinational bypass. The register loads on every rising clock edge on which the strobe is high. The bypass lets the outputs follow the data inputs while the strobe is high.

Top module: `latched_decoder`

## Requirements
- R1: While rstN is low, the held code resets to 0. After reset, with strobe and inhibit both low, line 0 is the active line.
- R2: While strobe is 1 and inhibit is 0, the active line is the one given by the present dataIn, in the same cycle, with no clock edge needed.
- R3: When strobe falls, the code sampled at the last rising clock edge with strobe high is held. Changes on dataIn while strobe is 0 do not change sel.
- R4: dataIn is an unsigned binary number with bit 0 as the least significant bit. Code n (0 to 15) selects line sel[n].
- R5: With ACTIVE_LOW = 0, the selected line is 1 and the other fifteen lines are 0.
- R6: With ACTIVE_LOW = 1, sel is the bitwise inverse of the active-high output for the same stimulus. The selected line is 0 and the others are 1.
- R7: While inhibit is 1, every line is at its inactive level (all 0 when active-high, all 1 when active-low), whatever dataIn and strobe are.
- R8: Inhibit does not disturb the held code. When inhibit returns to 0 with strobe still 0, the line that was selected before inhibit rose becomes active again.
- R9: While inhibit is 0, exactly one line is active. At all times sel is either one-hot or all inactive, after allowing for polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the holding register |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 4 | Binary code to decode |
| strobe | input | 1 | 1 = pass-through and load, 0 = hold |
| inhibit | input | 1 | 1 = force every line inactive |
| sel | output | 16 | Decoded lines, polarity set by ACTIVE_LOW |

## Verification
A sweep of all sixteen codes with strobe high checks the bit order and the one-to-one mapping. It would expose swapped or shifted address bits, and it runs on both polarity builds side by side. Hold sequences change dataIn after strobe falls, which tells a true capture apart from a stage that stays transparent. Inhibit pulses applied over a held code tell output blanking apart from clearing the stored code. A seeded random mix of codes, strobe and inhibit then checks the one-hot-or-blank rule against a reference model in the bench.

// File: rtl/latched_decoder_pkg.sv
package latched_decoder_pkg;

  // Control strobes handed from the control path to the datapath
  typedef struct packed {
    logic passThru;  // holding stage transparent, register loads
    logic blank;     // force all lines inactive
  } dec_ctrl_t;

endpackage

// File: rtl/latched_decoder_ctrl.sv
module latched_decoder_ctrl
  import latched_decoder_pkg::*;
(
  input  logic      strobe,
  input  logic      inhibit,
  output dec_ctrl_t ctrl
);

  always_comb begin
    ctrl.passThru = strobe;
    ctrl.blank    = inhibit;
  end

endmodule

// File: rtl/latched_decoder_dp.sv
module latched_decoder_dp
  import latched_decoder_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int OUT_W     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dataIn,
  input  dec_ctrl_t         ctrl,
  output logic [OUT_W-1:0]  selOut
);

  logic [ADDR_W-1:0] holdQ;
  logic [ADDR_W-1:0] codeSel;
  logic [OUT_W-1:0]  oneHot;
  logic [OUT_W-1:0]  activeVec;

  // Holding register: loads on every edge while transparent
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (ctrl.passThru) begin
      holdQ <= dataIn;
    end
  end

  // Transparent bypass around the register
  assign codeSel = ctrl.passThru ? dataIn : holdQ;

  // One comparator per line
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign oneHot[i] = !ctrl.blank && (codeSel == ADDR_W'(i));
  end

  // Polarity variant chosen at elaboration
  if (ACTIVE_LOW) begin : g_low
    assign selOut = ~oneHot;
  end else begin : g_high
    assign selOut = oneHot;
  end

  // Output viewed as active-high, for the checks below
  assign activeVec = ACTIVE_LOW ? ~selOut : selOut;

  AST_BLANK_ALL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.blank |-> (activeVec == '0)); // R7

  AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.blank |-> ($countones(activeVec) == 1)); // R9

  AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.passThru && !ctrl.blank) |-> activeVec[dataIn]); // R2

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.passThru && !$past(ctrl.passThru) && !ctrl.blank && !$past(ctrl.blank))
      |-> $stable(selOut)); // R3

  AST_UNBLANK_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctrl.blank) && !ctrl.passThru && !$past(ctrl.passThru))
      |-> activeVec[holdQ]); // R8

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder
  import latched_decoder_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int OUT_W     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dataIn,
  input  logic              strobe,
  input  logic              inhibit,
  output logic [OUT_W-1:0]  sel
);

  dec_ctrl_t ctrl;

  latched_decoder_ctrl u_ctrl (
    .strobe  (strobe),
    .inhibit (inhibit),
    .ctrl    (ctrl)
  );

  latched_decoder_dp #(
    .ADDR_W     (ADDR_W),
    .ACTIVE_LOW (ACTIVE_LOW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .ctrl   (ctrl),
    .selOut (sel)
  );

endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  dataIn = '0;
  logic        strobe = 1'b0;
  logic        inhibit = 1'b0;
  logic [15:0] selHigh;
  logic [15:0] selLow;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] modelHold = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  latched_decoder #(.ACTIVE_LOW(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .inhibit(inhibit), .sel(selHigh)
  );

  latched_decoder #(.ACTIVE_LOW(1'b1)) u_dutLow (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .inhibit(inhibit), .sel(selLow)
  );

  function automatic logic [15:0] expHigh(logic [3:0] code, logic inh);
    logic [15:0] v;
    v = '0;
    if (!inh) v[code] = 1'b1;
    return v;
  endfunction

  task automatic checkVal(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, check 1 ns later, update model for the coming posedge
  task automatic step(logic [3:0] d, logic stb, logic inh, string req);
    logic [15:0] e;
    @(negedge clk);
    dataIn = d; strobe = stb; inhibit = inh;
    #1;
    e = expHigh(stb ? d : modelHold, inh);
    checkVal(req, selHigh, e);
    checkVal({req, "/R6"}, selLow, ~e);
    if (stb) modelHold = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    #1;
    // R1: reset value selects line 0
    checkVal("R1", selHigh, 16'h0001);
    checkVal("R1/R6", selLow, 16'hFFFE);
    @(negedge clk);
    rstN = 1'b1;
    modelHold = '0;
    step(4'd0, 1'b0, 1'b0, "R1");

    // R2, R4, R5, R6: sweep all codes while transparent
    for (int n = 0; n < 16; n++) begin
      step(4'(n), 1'b1, 1'b0, "R2/R4/R5");
    end
    // R4: bit order, code 1 vs 8
    step(4'b0001, 1'b1, 1'b0, "R4");
    checkVal("R4", selHigh, 16'h0002);
    step(4'b1000, 1'b1, 1'b0, "R4");
    checkVal("R4", selHigh, 16'h0100);

    // R3: capture 9, then wiggle data with strobe low
    step(4'd9, 1'b1, 1'b0, "R3");
    step(4'd2, 1'b0, 1'b0, "R3");
    checkVal("R3", selHigh, 16'h0200);
    step(4'd15, 1'b0, 1'b0, "R3");
    step(4'd0, 1'b0, 1'b0, "R3");
    checkVal("R3", selHigh, 16'h0200);

    // R7, R8: inhibit over held code
    step(4'd5, 1'b0, 1'b1, "R7");
    checkVal("R7", selHigh, 16'h0000);
    checkVal("R7", selLow, 16'hFFFF);
    step(4'd12, 1'b1, 1'b1, "R7");
    step(4'd3, 1'b0, 1'b1, "R7");
    step(4'd3, 1'b0, 1'b0, "R8");
    checkVal("R8", selHigh, 16'h1000);
    step(4'd6, 1'b0, 1'b1, "R8");
    step(4'd7, 1'b0, 1'b0, "R8");
    checkVal("R8", selHigh, 16'h1000);

    // R9 and mixed: seeded random traffic
    for (int k = 0; k < 400; k++) begin
      logic [3:0] d;
      logic s, h;
      d = 4'($urandom);
      s = ($urandom % 3) == 0;
      h = ($urandom % 5) == 0;
      step(d, s, h, "R9");
      compared++;
      if ($countones(selHigh) != (h ? 0 : 1)) begin
        mismatched++;
        $display("FAIL R9: actual ones %0d expected %0d", $countones(selHigh), h ? 0 : 1);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule